// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the combinational integer stage of a simple pipeline. Each evaluation takes two register operands, a constant shift amount, a 6-bit function code, an immediate-mode flag and a 16-bit immediate. It returns a result word, a register write enable and an overflow trap. The whole path settles within one cycle, and no state is kept.

The unit covers addition, subtraction, the bitwise operations, signed and unsigned less-than tests and constant shifts. Add and subtract each have a trapping form and a non-trapping form, and both forms give the same sum. Only the trapping form can raise the trap. When the trap rises, the write enable drops so the destination register keeps its old value.

In immediate mode the immediate replaces the second operand and the same function codes select the operation. The immediate is sign-extended for the arithmetic and compare codes, including the non-trapping add. It is zero-extended for the bitwise codes.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0x20 and code 0x21 both give opA + B modulo 2^32. Code 0x20 raises `trap` when the signed sum overflows. Code 0x21 never raises `trap`.
- R2: Code 0x22 and code 0x23 both give opA - B modulo 2^32. Code 0x22 raises `trap` on signed overflow. Code 0x23 never raises `trap`. No code other than 0x20 and 0x22 raises `trap`.
- R3: When `trap` is high, `writeEn` is low in the same evaluation. For every code listed in R1, R2, R4, R5 and R6, `writeEn` is high whenever `trap` is low.
- R4: The bitwise codes are 0x24 (AND), 0x25 (OR), 0x26 (XOR) and 0x27 (NOR). Each applies its operation between opA and B.
- R5: Code 0x2A gives 1 when opA is below B as signed two's complement values, and 0 otherwise. Code 0x2B makes the same comparison unsigned. All upper result bits are 0.
- R6: The shift codes act on opA by `shamt` positions. Code 0x00 is a left shift. Code 0x02 is a right shift that fills with zeros. Code 0x03 is a right shift that fills with opA bit 31.
- R7: B is `opB` when `immMode` is 0. When `immMode` is 1, B is `imm`, sign-extended for codes 0x20 to 0x23, 0x2A and 0x2B and zero-extended for codes 0x24 to 0x27. Shifts ignore both `opB` and `imm`.
- R8: An all-zero input set (code 0x00, `shamt` 0, opA 0) acts as a no-op. The result is 0, `writeEn` is 1 and `trap` is 0.
- R9: Any code not listed above gives a result of 0, `writeEn` 0 and `trap` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand, also the value that is shifted |
| opB | input | 32 | Second operand in register mode |
| imm | input | 16 | Immediate used as second operand in immediate mode |
| shamt | input | 5 | Constant shift distance |
| funct | input | 6 | Operation code |
| immMode | input | 1 | Selects the immediate as second operand |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Register write permitted |
| trap | output | 1 | Signed overflow trap on the trapping add and subtract |

## Verification
The bench builds the unit with its default 32-bit data path and 16-bit immediate. At these widths the signed overflow boundaries at 0x7FFFFFFF and 0x80000000 can be reached directly. The sign bit of the immediate at 0xFFFF shows whether it was extended with its sign or with zeros. All five shift stages, including the full shift by 31, come into play. Random operands are biased toward the extreme values so that both overflow directions occur often for add and for subtract.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA
  } opSel_e;

  typedef struct packed {
    opSel_e opSel;
    logic   useImm;
    logic   immSext;
    logic   trapEn;
    logic   legal;
  } ctrlStrobes_t;

endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
(
  input  logic [5:0]   funct,
  input  logic         immMode,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes         = '0;
    strobes.opSel   = OP_NONE;
    strobes.useImm  = immMode;
    unique case (funct)
      FN_SLL:  begin strobes.opSel = OP_SLL;  strobes.legal = 1'b1; end
      FN_SRL:  begin strobes.opSel = OP_SRL;  strobes.legal = 1'b1; end
      FN_SRA:  begin strobes.opSel = OP_SRA;  strobes.legal = 1'b1; end
      FN_ADD:  begin strobes.opSel = OP_ADD;  strobes.legal = 1'b1;
                     strobes.immSext = 1'b1;  strobes.trapEn = 1'b1; end
      FN_ADDU: begin strobes.opSel = OP_ADD;  strobes.legal = 1'b1;
                     strobes.immSext = 1'b1; end
      FN_SUB:  begin strobes.opSel = OP_SUB;  strobes.legal = 1'b1;
                     strobes.immSext = 1'b1;  strobes.trapEn = 1'b1; end
      FN_SUBU: begin strobes.opSel = OP_SUB;  strobes.legal = 1'b1;
                     strobes.immSext = 1'b1; end
      FN_AND:  begin strobes.opSel = OP_AND;  strobes.legal = 1'b1; end
      FN_OR:   begin strobes.opSel = OP_OR;   strobes.legal = 1'b1; end
      FN_XOR:  begin strobes.opSel = OP_XOR;  strobes.legal = 1'b1; end
      FN_NOR:  begin strobes.opSel = OP_NOR;  strobes.legal = 1'b1; end
      FN_SLT:  begin strobes.opSel = OP_SLT;  strobes.legal = 1'b1;
                     strobes.immSext = 1'b1; end
      FN_SLTU: begin strobes.opSel = OP_SLTU; strobes.legal = 1'b1;
                     strobes.immSext = 1'b1; end
      default: begin strobes.opSel = OP_NONE; end
    endcase
  end

endmodule

// File: rtl/int_exec_shifter.sv
module int_exec_shifter #(
  parameter int WIDTH = 32,
  localparam int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   value,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               arith,
  output logic [WIDTH-1:0]   leftOut,
  output logic [WIDTH-1:0]   rightOut
);

  logic [WIDTH-1:0] lStage [SHAMT_W+1];
  logic [WIDTH-1:0] rStage [SHAMT_W+1];
  logic             fillBit;

  assign fillBit   = arith & value[WIDTH-1];
  assign lStage[0] = value;
  assign rStage[0] = value;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign lStage[k+1] = shamt[k] ? {lStage[k][WIDTH-1-DIST:0], {DIST{1'b0}}}
                                  : lStage[k];
    assign rStage[k+1] = shamt[k] ? {{DIST{fillBit}}, rStage[k][WIDTH-1:DIST]}
                                  : rStage[k];
  end

  assign leftOut  = lStage[SHAMT_W];
  assign rightOut = rStage[SHAMT_W];

endmodule

// File: rtl/int_exec_datapath.sv
module int_exec_datapath
  import int_exec_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  localparam int SHAMT_W = $clog2(WIDTH),
  localparam int EXT_W = WIDTH - IMM_W
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  ctrlStrobes_t       strobes,
  output logic [WIDTH-1:0]   result,
  output logic               ovf
);

  logic [WIDTH-1:0] immExt;
  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] shlOut;
  logic [WIDTH-1:0] shrOut;
  logic             sgnA;
  logic             sgnB;

  assign immExt = strobes.immSext ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                  : {{EXT_W{1'b0}}, imm};
  assign bEff   = strobes.useImm ? immExt : opB;
  assign sum    = opA + bEff;
  assign diff   = opA - bEff;
  assign sgnA   = opA[WIDTH-1];
  assign sgnB   = bEff[WIDTH-1];

  int_exec_shifter #(.WIDTH(WIDTH)) u_shifter (
    .value   (opA),
    .shamt   (shamt),
    .arith   (strobes.opSel == OP_SRA),
    .leftOut (shlOut),
    .rightOut(shrOut)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    unique case (strobes.opSel)
      OP_ADD:  begin
        result = sum;
        ovf    = (sgnA == sgnB) && (sum[WIDTH-1] != sgnA);
      end
      OP_SUB:  begin
        result = diff;
        ovf    = (sgnA != sgnB) && (diff[WIDTH-1] != sgnA);
      end
      OP_AND:  result = opA & bEff;
      OP_OR:   result = opA | bEff;
      OP_XOR:  result = opA ^ bEff;
      OP_NOR:  result = ~(opA | bEff);
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, $signed(opA) < $signed(bEff)};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, opA < bEff};
      OP_SLL:  result = shlOut;
      OP_SRL,
      OP_SRA:  result = shrOut;
      default: result = '0;
    endcase
  end

  always_comb begin
    // R6
    if ((strobes.opSel == OP_SLL || strobes.opSel == OP_SRL ||
         strobes.opSel == OP_SRA) && shamt == '0)
      zero_shift_chk: assert (result == opA);
    // R2
    if (strobes.opSel != OP_ADD && strobes.opSel != OP_SUB)
      no_overflow_chk: assert (!ovf);
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  localparam int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [5:0]         funct,
  input  logic               immMode,
  output logic [WIDTH-1:0]   result,
  output logic               writeEn,
  output logic               trap
);

  ctrlStrobes_t strobes;
  logic         ovf;

  int_exec_ctrl u_ctrl (
    .funct  (funct),
    .immMode(immMode),
    .strobes(strobes)
  );

  int_exec_datapath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_datapath (
    .opA    (opA),
    .opB    (opB),
    .imm    (imm),
    .shamt  (shamt),
    .strobes(strobes),
    .result (result),
    .ovf    (ovf)
  );

  assign trap    = ovf & strobes.trapEn;
  assign writeEn = strobes.legal & ~trap;

  always_comb begin
    // R3
    trap_blocks_write_chk: assert (!(trap && writeEn));
    // R2
    if (funct != FN_ADD && funct != FN_SUB)
      trap_code_chk: assert (!trap);
    // R5
    if (funct == FN_SLT || funct == FN_SLTU)
      compare_bit_chk: assert (result[WIDTH-1:1] == '0);
    // R9
    if (!strobes.legal)
      unknown_code_chk: assert (!writeEn && result == '0);
  end

endmodule

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;

  logic        clk = 1'b0;
  logic [31:0] opA, opB;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [5:0]  funct;
  logic        immMode;
  logic [31:0] result;
  logic        writeEn, trap;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .opA(opA), .opB(opB), .imm(imm), .shamt(shamt), .funct(funct),
    .immMode(immMode), .result(result), .writeEn(writeEn), .trap(trap)
  );

  function automatic logic [33:0] refModel(
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
      input logic [4:0] sh, input logic [5:0] fn, input logic useIm);
    logic [31:0] bx, r;
    logic        we, tr;
    longint      wide;
    bit          arith, logicOp;
    arith   = (fn >= 6'h20 && fn <= 6'h23) || fn == 6'h2A || fn == 6'h2B;
    logicOp = (fn >= 6'h24 && fn <= 6'h27);
    bx = b;
    if (useIm) bx = arith ? {{16{im[15]}}, im} : {16'h0, im};
    r = 32'h0; we = 1'b1; tr = 1'b0;
    case (fn)
      6'h00: r = a << sh;
      6'h02: r = a >> sh;
      6'h03: r = 32'($signed(a) >>> sh);
      6'h20, 6'h21: begin
        r = a + bx;
        wide = longint'($signed(a)) + longint'($signed(bx));
        tr = (fn == 6'h20) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      6'h22, 6'h23: begin
        r = a - bx;
        wide = longint'($signed(a)) - longint'($signed(bx));
        tr = (fn == 6'h22) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      6'h24: r = a & bx;
      6'h25: r = a | bx;
      6'h26: r = a ^ bx;
      6'h27: r = ~(a | bx);
      6'h2A: r = ($signed(a) < $signed(bx)) ? 32'd1 : 32'd0;
      6'h2B: r = (a < bx) ? 32'd1 : 32'd0;
      default: begin r = 32'h0; we = 1'b0; end
    endcase
    if (tr) we = 1'b0;
    if (logicOp) ;
    return {r, we, tr};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                     input logic [4:0] sh, input logic [5:0] fn, input logic useIm,
                     input string tag);
    logic [33:0] e;
    @(negedge clk);
    opA = a; opB = b; imm = im; shamt = sh; funct = fn; immMode = useIm;
    #2;
    e = refModel(a, b, im, sh, fn, useIm);
    check({tag, " result"}, result, e[33:2]);
    check({tag, " writeEn"}, {31'h0, writeEn}, {31'h0, e[1]});
    check({tag, " trap"}, {31'h0, trap}, {31'h0, e[0]});
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom_range(0, 5))
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'hFFFFFFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] codes [15];
    codes = '{6'h00, 6'h02, 6'h03, 6'h20, 6'h21, 6'h22, 6'h23, 6'h24,
              6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B, 6'h3F, 6'h01};
    void'($urandom(32'd1234));
    opA = 0; opB = 0; imm = 0; shamt = 0; funct = 0; immMode = 0;
    // R8 reset-state no-op
    run(32'h0, 32'h0, 16'h0, 5'd0, 6'h00, 1'b0, "R8 nop");
    // R1 overflow corners
    run(32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 6'h20, 1'b0, "R1 add trap");
    run(32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 6'h21, 1'b0, "R1 addu no trap");
    run(32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0, 6'h20, 1'b0, "R1 add neg trap");
    // R2 subtract corners
    run(32'h80000000, 32'h1, 16'h0, 5'd0, 6'h22, 1'b0, "R2 sub trap");
    run(32'h80000000, 32'h1, 16'h0, 5'd0, 6'h23, 1'b0, "R2 subu no trap");
    run(32'h0, 32'h80000000, 16'h0, 5'd0, 6'h22, 1'b0, "R2 sub min trap");
    // R3 trap blocks write
    run(32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 5'd0, 6'h20, 1'b0, "R3 write blocked");
    // R4 bitwise
    run(32'hF0F0A5A5, 32'h0FF0FFFF, 16'h0, 5'd0, 6'h27, 1'b0, "R4 nor");
    run(32'hF0F0A5A5, 32'h0FF0FFFF, 16'h0, 5'd0, 6'h26, 1'b0, "R4 xor");
    // R5 compares
    run(32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 6'h2A, 1'b0, "R5 slt signed");
    run(32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 6'h2B, 1'b0, "R5 sltu unsigned");
    // R6 shifts
    run(32'h80000001, 32'h0, 16'h0, 5'd31, 6'h03, 1'b0, "R6 sra 31");
    run(32'h80000001, 32'h0, 16'h0, 5'd31, 6'h02, 1'b0, "R6 srl 31");
    run(32'h80000001, 32'h0, 16'h0, 5'd31, 6'h00, 1'b0, "R6 sll 31");
    // R7 immediate extension
    run(32'h00000005, 32'h12345678, 16'hFFFF, 5'd0, 6'h21, 1'b1, "R7 addu sext");
    run(32'h00000000, 32'h12345678, 16'hFFFF, 5'd0, 6'h25, 1'b1, "R7 or zext");
    run(32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 6'h20, 1'b1, "R7 addi trap");
    run(32'h00000000, 32'h0, 16'h8000, 5'd0, 6'h2A, 1'b1, "R7 slti sext");
    run(32'h0000F00F, 32'hFFFFFFFF, 16'hABCD, 5'd4, 6'h00, 1'b1, "R7 shift ignores imm");
    // R9 unknown codes
    run(32'hDEADBEEF, 32'h1, 16'h0, 5'd3, 6'h3F, 1'b0, "R9 unknown 3F");
    run(32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 6'h01, 1'b0, "R9 unknown 01");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fn;
      fn = codes[$urandom_range(0, 14)];
      run(pickVal(), pickVal(), 16'($urandom), 5'($urandom), fn, 1'($urandom),
          "R1 R2 R4 R5 R6 R7 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule